// File: doc/BRIEF.md
# Command-Mode Parallel Panel Write Sequencer

This block sends one frame of pixel or command words to a panel with a parallel bus in 8080 style. It drives an active-low chip select, an active-low write strobe and a data bus. Four cycle counts in a configuration word shape each write: chip-select lead time, data setup before the strobe, strobe width and hold after the strobe. Words come from a valid/ready stream. Every write waits for the next word, so a slow source stretches the frame and never corrupts it.

Software writes a trigger command to start a frame. From then until the frame ends, the block is in triggering mode and drops further trigger commands, because a second start in the middle of a frame could reset the panel. When the last hold period ends, chip select is released, a frame-done pending flag is set and triggering mode ends, all in the same cycle. The pending flag drives the interrupt line through an enable and is cleared by writing one.

Top module: `i80_strobe_seq`

## Requirements
- R1: After reset, cs_n and wr_n are 1, and busy, irq_pend, irq and src_ready are 0.
- R2: The configuration word has an enable bit at bit 0. It carries chip-select lead cycles in bits 19:16, write setup in 15:12, strobe width in 11:8 and hold in 7:4. A trigger write starts a frame only if trig_data is 2'b11, with bit 0 selecting trigger mode and bit 1 the start command, and only if the enable bit is 1. Otherwise the write is dropped and busy stays 0.
- R3: busy and chip select assert in the cycle after an accepted trigger. With the source always valid, wr_n first falls after exactly cs_setup + 1 + wr_setup cycles in which chip select is low.
- R4: Each strobe holds wr_n low for exactly wr_active cycles. A wr_active of 0 acts as 1.
- R5: Each strobe carries the next stream word in order on db, steady for the whole low period. With the source always valid, wr_n stays high for exactly hold + 1 + wr_setup cycles between strobes.
- R6: cs_n stays low across the whole frame. It gives exactly frame_len strobes and rises hold cycles after the last rising edge of wr_n.
- R7: A trigger write while busy is 1 has no effect. The running frame keeps its length and no new frame follows it.
- R8: In the cycle cs_n rises, irq_pend becomes 1 and busy becomes 0. irq equals irq_pend AND irq_en. Pulsing irq_clr clears irq_pend.
- R9: The timing fields and frame_len are captured at the accepted trigger. Changes to them during a frame do not affect that frame.
- R10: A trigger with frame_len equal to 0 is dropped.
- R11: While the source is stalled, chip select stays low and wr_n stays high. The sequence resumes when a word arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_word | input | 20 | Timing fields and enable bit |
| frame_len | input | LEN_W | Words per frame, captured at trigger |
| trig_wr | input | 1 | Trigger register write strobe |
| trig_data | input | 2 | Trigger write value: bit 0 mode, bit 1 start |
| irq_en | input | 1 | Frame-done interrupt enable |
| irq_clr | input | 1 | Write-one-to-clear of the pending flag |
| src_valid | input | 1 | Stream word valid |
| src_data | input | DATA_W | Stream word |
| src_ready | output | 1 | Word taken at this clock edge when valid |
| cs_n | output | 1 | Panel chip select, active low |
| wr_n | output | 1 | Panel write strobe, active low |
| db | output | DATA_W | Panel data bus |
| busy | output | 1 | Triggering mode active |
| irq_pend | output | 1 | Frame-done pending flag |
| irq | output | 1 | Frame-done interrupt |

## Verification
A phase counter that loads the wrong value shows up within a single word as a strobe or a gap whose width is off by whole cycles. A word counter that is off adds or drops a strobe, and the cs_n rise shows this at the end of the same frame. A lockout flag that clears early lets a second trigger start a new frame straight after the first, and a pending flag or busy flag out of step with chip select is visible in the cycle cs_n rises. Data held in the wrong register appears as a wrong or out-of-order word at the very strobe that carries it.

// File: rtl/i80_seq_pkg.sv
package i80_seq_pkg;
  localparam int PH_W = 4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CSU, ST_LOAD, ST_WSU, ST_ACT, ST_HOLD
  } seq_st_e;

  typedef struct packed {
    logic [PH_W-1:0] cs_su;
    logic [PH_W-1:0] wr_su;
    logic [PH_W-1:0] wr_act;
    logic [PH_W-1:0] wr_hold;
  } tim_t;

  // field positions: 19:16 cs lead, 15:12 setup, 11:8 width, 7:4 hold
  function automatic tim_t cfg_timing(input logic [19:0] w);
    tim_t t;
    t.cs_su   = w[19:16];
    t.wr_su   = w[15:12];
    t.wr_act  = w[11:8];
    t.wr_hold = w[7:4];
    return t;
  endfunction

  // strobe width of zero is stretched to one cycle
  function automatic logic [PH_W-1:0] strobe_len(input logic [PH_W-1:0] a);
    return (a == '0) ? PH_W'(1) : a;
  endfunction
endpackage

// File: rtl/i80_trig_ctrl.sv
module i80_trig_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       trig_wr,
  input  logic [1:0] trig_data,
  input  logic       cfg_en,
  input  logic       len_nz,
  input  logic       frame_done,
  input  logic       irq_en,
  input  logic       irq_clr,
  output logic       start,
  output logic       busy,
  output logic       pend,
  output logic       irq
);
  logic trig_cmd;
  assign trig_cmd = trig_wr && (trig_data == 2'b11);
  assign start    = trig_cmd && cfg_en && len_nz && !busy;
  assign irq      = pend && irq_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      pend <= 1'b0;
    end else begin
      if (start)           busy <= 1'b1;
      else if (frame_done) busy <= 1'b0;
      if (frame_done)      pend <= 1'b1;
      else if (irq_clr)    pend <= 1'b0;
    end
  end

  p_disabled_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !cfg_en) |=> !busy);
  p_done_sets_pend_r8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> (pend && !busy));
  p_busy_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !frame_done) |=> busy);
endmodule

// File: rtl/i80_strobe_fsm.sv
module i80_strobe_fsm
  import i80_seq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int LEN_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  tim_t              tim_in,
  input  logic [LEN_W-1:0]  len_in,
  input  logic              src_valid,
  input  logic [DATA_W-1:0] src_data,
  output logic              src_ready,
  output logic              cs_n,
  output logic              wr_n,
  output logic [DATA_W-1:0] db,
  output logic              frame_done
);
  seq_st_e          st_q, st_d;
  logic [PH_W-1:0]  cnt_q, cnt_d;
  logic [LEN_W-1:0] rem_q;
  tim_t             tim_q;
  logic [DATA_W-1:0] db_q;
  logic             take;
  logic             ph_end;

  assign ph_end    = (cnt_q == '0);
  assign take      = (st_q == ST_LOAD) && src_valid;
  assign src_ready = (st_q == ST_LOAD);
  assign cs_n      = (st_q == ST_IDLE);
  assign wr_n      = (st_q != ST_ACT);
  assign db        = db_q;

  always_comb begin
    st_d       = st_q;
    cnt_d      = (cnt_q == '0) ? cnt_q : cnt_q - 1'b1;
    frame_done = 1'b0;
    case (st_q)
      ST_IDLE: if (start) begin
        if (tim_in.cs_su != '0) begin
          st_d  = ST_CSU;
          cnt_d = tim_in.cs_su - 1'b1;
        end else begin
          st_d = ST_LOAD;
        end
      end
      ST_CSU: if (ph_end) st_d = ST_LOAD;
      ST_LOAD: if (src_valid) begin
        if (tim_q.wr_su != '0) begin
          st_d  = ST_WSU;
          cnt_d = tim_q.wr_su - 1'b1;
        end else begin
          st_d  = ST_ACT;
          cnt_d = strobe_len(tim_q.wr_act) - 1'b1;
        end
      end
      ST_WSU: if (ph_end) begin
        st_d  = ST_ACT;
        cnt_d = strobe_len(tim_q.wr_act) - 1'b1;
      end
      ST_ACT: if (ph_end) begin
        if (tim_q.wr_hold != '0) begin
          st_d  = ST_HOLD;
          cnt_d = tim_q.wr_hold - 1'b1;
        end else if (rem_q == '0) begin
          st_d       = ST_IDLE;
          frame_done = 1'b1;
        end else begin
          st_d = ST_LOAD;
        end
      end
      ST_HOLD: if (ph_end) begin
        if (rem_q == '0) begin
          st_d       = ST_IDLE;
          frame_done = 1'b1;
        end else begin
          st_d = ST_LOAD;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      rem_q <= '0;
      tim_q <= '0;
      db_q  <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      if (start && st_q == ST_IDLE) begin
        tim_q <= tim_in;
        rem_q <= len_in;
      end else if (take) begin
        rem_q <= rem_q - 1'b1;
      end
      if (take) db_q <= src_data;
    end
  end

  p_wr_in_cs_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> !cs_n);
  p_db_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |=> (wr_n || $stable(db)));
  p_ready_in_frame_r11: assert property (@(posedge clk) disable iff (!rst_n)
    src_ready |-> (!cs_n && wr_n));
endmodule

// File: rtl/i80_strobe_seq.sv
module i80_strobe_seq
  import i80_seq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int LEN_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [19:0]       cfg_word,
  input  logic [LEN_W-1:0]  frame_len,
  input  logic              trig_wr,
  input  logic [1:0]        trig_data,
  input  logic              irq_en,
  input  logic              irq_clr,
  input  logic              src_valid,
  input  logic [DATA_W-1:0] src_data,
  output logic              src_ready,
  output logic              cs_n,
  output logic              wr_n,
  output logic [DATA_W-1:0] db,
  output logic              busy,
  output logic              irq_pend,
  output logic              irq
);
  logic start;
  logic frame_done;
  tim_t tim;

  assign tim = cfg_timing(cfg_word);

  i80_trig_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .trig_wr(trig_wr), .trig_data(trig_data),
    .cfg_en(cfg_word[0]), .len_nz(frame_len != '0), .frame_done(frame_done),
    .irq_en(irq_en), .irq_clr(irq_clr), .start(start), .busy(busy),
    .pend(irq_pend), .irq(irq)
  );

  i80_strobe_fsm #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .tim_in(tim), .len_in(frame_len),
    .src_valid(src_valid), .src_data(src_data), .src_ready(src_ready),
    .cs_n(cs_n), .wr_n(wr_n), .db(db), .frame_done(frame_done)
  );

  p_busy_tracks_cs_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |-> (busy == !cs_n));
endmodule

// File: tb/tb_i80_strobe_seq.sv
module tb_i80_strobe_seq;
  localparam int DW = 16;
  localparam int LW = 12;

  logic clk = 0, rst_n = 0;
  logic [19:0] cfg_word = '0;
  logic [LW-1:0] frame_len = '0;
  logic trig_wr = 0, irq_en = 0, irq_clr = 0, src_valid = 0;
  logic [1:0] trig_data = '0;
  logic [DW-1:0] src_data = '0;
  logic src_ready, cs_n, wr_n, busy, irq_pend, irq;
  logic [DW-1:0] db;

  always #10 clk = ~clk;

  i80_strobe_seq #(.DATA_W(DW), .LEN_W(LW)) dut (.*);

  int nchk = 0, nfail = 0;
  logic [DW-1:0] src_q[$];
  logic [DW-1:0] exp_q[$];
  int e_first, e_gap, e_act, e_hold, e_len;
  bit stall_mode = 0;
  int cyc = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [19:0] mk_cfg(bit en, int cs, int ws, int a, int h);
    return {4'(cs), 4'(ws), 4'(a), 4'(h), 3'b0, en};
  endfunction

  // stream source: pops a word one negedge after the edge that took it
  bit took = 0;
  always @(negedge clk) begin
    cyc++;
    if (took && src_q.size() > 0) void'(src_q.pop_front());
    if (src_q.size() > 0 && !(stall_mode && cyc % 4 != 0)) begin
      src_valid = 1;
      src_data  = src_q[0];
    end else begin
      src_valid = 0;
    end
    took = src_valid && src_ready;
  end

  // monitor / scoreboard
  logic prev_cs = 1, prev_wr = 1;
  bit first = 0;
  int hi_cnt = 0, lo_cnt = 0, nstrobe = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_cs && !cs_n) begin
        first = 1; hi_cnt = 0; nstrobe = 0;
      end
      if (prev_wr && !wr_n) begin
        if (!stall_mode) begin
          if (first) chk(hi_cnt == e_first, "R3 first strobe delay", hi_cnt, e_first);
          else       chk(hi_cnt == e_gap, "R5 inter-strobe gap", hi_cnt, e_gap);
        end
        first = 0; lo_cnt = 1; hi_cnt = 0; nstrobe++;
        if (exp_q.size() == 0) chk(0, "R6 extra strobe", nstrobe, e_len);
        else begin
          logic [DW-1:0] e;
          e = exp_q.pop_front();
          chk(db == e, "R5 data word", int'(db), int'(e));
        end
      end else if (!wr_n) begin
        lo_cnt++;
      end
      if (!prev_wr && wr_n) begin
        chk(lo_cnt == e_act, "R4 strobe width", lo_cnt, e_act);
        hi_cnt = 0;
      end
      if (!cs_n && wr_n) hi_cnt++;
      if (!prev_cs && cs_n) begin
        chk(hi_cnt == e_hold, "R6 final hold", hi_cnt, e_hold);
        chk(nstrobe == e_len, "R6 strobe count", nstrobe, e_len);
        chk(irq_pend && !busy, "R8 pend set busy clear", {irq_pend, busy}, 2);
        chk(irq == irq_en, "R8 irq gating", irq, irq_en);
      end
      prev_cs = cs_n; prev_wr = wr_n;
    end
  end

  task automatic trig(input logic [1:0] v);
    @(negedge clk); trig_wr = 1; trig_data = v;
    @(negedge clk); trig_wr = 0; trig_data = 0;
  endtask

  // mode: 0 plain, 1 retrigger while busy, 2 change config mid-frame
  task automatic run_frame(input logic [19:0] cfg, input int len, input int seed, input int mode);
    int cs = cfg[19:16], ws = cfg[15:12], a = cfg[11:8], h = cfg[7:4];
    e_act = (a == 0) ? 1 : a;
    e_first = cs + 1 + ws; e_gap = h + 1 + ws; e_hold = h; e_len = len;
    for (int i = 0; i < len; i++) begin
      src_q.push_back(DW'(seed + i * 37));
      exp_q.push_back(DW'(seed + i * 37));
    end
    cfg_word = cfg; frame_len = LW'(len);
    trig(2'b11);
    chk(busy && !cs_n, "R3 trigger accepted", busy, 1);
    if (mode == 2) begin
      cfg_word = mk_cfg(1, 5, 5, 5, 5); frame_len = LW'(len + 3);  // R9
    end
    if (mode == 1) begin
      repeat (3) @(negedge clk);
      trig(2'b11);                                                // R7
    end
    while (busy) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(cs_n && !busy, "R7 no frame after end", busy, 0);
    chk(exp_q.size() == 0, "R5 all words written", exp_q.size(), 0);
    @(negedge clk); irq_clr = 1;
    @(negedge clk); irq_clr = 0;
    chk(!irq_pend && !irq, "R8 write-one clear", irq_pend, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(cs_n && wr_n && !busy && !irq_pend && !irq && !src_ready,
        "R1 reset state", {cs_n, wr_n, busy, irq_pend}, 4'b1100);
    rst_n = 1;
    @(negedge clk);
    irq_en = 1;
    run_frame(mk_cfg(1, 0, 0, 1, 0), 3, 16'h100, 0);   // default timing
    run_frame(mk_cfg(1, 2, 3, 4, 2), 4, 16'h2A0, 0);
    irq_en = 0;
    run_frame(mk_cfg(1, 0, 0, 0, 1), 2, 16'h3F1, 0);   // R4 width 0 -> 1
    irq_en = 1;
    // R2 disabled, R2 mode bit missing, R10 zero length
    cfg_word = mk_cfg(0, 1, 1, 1, 1); frame_len = 4;
    trig(2'b11); repeat (5) @(negedge clk);
    chk(!busy && cs_n, "R2 disabled trigger dropped", busy, 0);
    cfg_word = mk_cfg(1, 1, 1, 1, 1);
    trig(2'b10); repeat (5) @(negedge clk);
    chk(!busy && cs_n, "R2 trigger without mode bit", busy, 0);
    trig(2'b01); repeat (5) @(negedge clk);
    chk(!busy && cs_n, "R2 mode bit without start", busy, 0);
    frame_len = 0;
    trig(2'b11); repeat (5) @(negedge clk);
    chk(!busy && cs_n, "R10 zero-length trigger dropped", busy, 0);
    run_frame(mk_cfg(1, 1, 2, 3, 1), 5, 16'h055, 1);   // R7 retrigger
    run_frame(mk_cfg(1, 3, 1, 2, 2), 3, 16'h777, 2);   // R9 latched config
    stall_mode = 1;
    run_frame(mk_cfg(1, 1, 1, 2, 1), 6, 16'h900, 0);   // R11 stalled source
    stall_mode = 0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end
endmodule